// File: doc/BRIEF.md
# Chopped-ADC Offset Estimator and Trim Controller

This block sits behind a pipelined ADC whose analog path is chopped by pseudo-random sign sequences. For every chopped point in the analog chain (called a stage here) it issues one chop bit per clock. It receives the signed raw conversion result together with a valid strobe. The ADC has a fixed latency, so the block delays its own chop bits internally until they line up with the code that comes out. Because chopping turns the wanted signal into zero-mean noise, an additive offset is recovered by averaging. Over a block of 2^LOG2_N valid samples, stage 0 takes the plain mean of the raw codes. Every other stage takes the mean of the raw code multiplied by that stage's own sign stream.

Each corrected sample is the raw code minus the current stage-0 estimate, de-chopped with the sign that was applied to that sample. When feedback is enabled, each stage also steps a source-side trim code by one count at every block end. The step direction opposes the sign of that stage's estimate, so the loop drives the measured offset towards zero. The trim is a 4-bit coarse field above a fine field. The fine field carries into the coarse field, and the combined code saturates at both ends.

Top module: `cofs_ctrl`

## Requirements
- R1: While reset is held and until the first clock edge after it is released, the block shows the following state. corr_vld_o and est_vld_o are 0 and every estimate is 0. Every trim code has coarse field 8 (mid-scale of 4 bits) and fine field 0. chop_o[s] equals bit 0 of that stage's seed.
- R2: Each stage runs a 31-bit shift register. On every clock it shifts left by one place, and the new bit 0 is bit 30 XOR bit 27. Its reset value is SEED XOR (s shifted left by 20). chop_o[s] is its bit 0 and advances every clock whether or not a sample is valid. A chop bit of 0 means +1 and a chop bit of 1 means -1.
- R3: A raw code presented with raw_vld_i in cycle c is paired with the chop values that chop_o showed in cycle c-LAT.
- R4: Every 2^LOG2_N valid samples form one block. In the cycle after a block's last sample, est_vld_o is 1 for exactly one cycle. In that same cycle, the stage-0 estimate becomes floor(sum of the block's raw codes / 2^LOG2_N).
- R5: At the same update, the estimate of each stage s >= 1 becomes floor(sum over the block of raw code times stage s's sign / 2^LOG2_N).
- R6: In the cycle after a valid raw code arrives, corr_vld_o is 1 and corr_code_o holds (raw - E0) times the stage-0 sign paired with that code. E0 is the stage-0 estimate held before any update at that same edge.
- R7: A cycle with raw_vld_i low has no effect on the sample count or the accumulators, and corr_vld_o is 0 in the following cycle.
- R8: fb_en_i is sampled in a cycle where est_vld_o is 1. If it is high, then in the next cycle each stage's combined trim T = coarse*2^FINE_W + fine falls by 1 when that stage's estimate is positive, rises by 1 when it is negative, and stays put when it is zero. If fb_en_i is low, or est_vld_o is 0, T does not change.
- R9: The combined trim saturates at 0 and at 2^(4+FINE_W)-1. A fine field that steps past either end carries into or borrows from the coarse field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_vld_i | input | 1 | Raw ADC code valid |
| raw_code_i | input | CODE_W | Signed raw ADC code |
| fb_en_i | input | 1 | Enable source-side trim stepping |
| chop_o | output | NSTG | Chop bit per stage (1 = negative) |
| corr_vld_o | output | 1 | Corrected sample valid |
| corr_code_o | output | CODE_W+2 | Signed corrected, de-chopped sample |
| est_vld_o | output | 1 | One-cycle pulse on estimate update |
| est_o | output | NSTG*(CODE_W+1) | Signed estimate per stage, stage 0 in the low bits |
| trim_coarse_o | output | NSTG*4 | Coarse trim field per stage |
| trim_fine_o | output | NSTG*FINE_W | Fine trim field per stage |

## Verification
Several kinds of traffic are used. Continuous samples with a wide random signal and fixed, differing offsets on the two stages show that each estimator picks out only its own stage's term. Gapped traffic shows that idle cycles neither count towards a block nor disturb the pairing of chop bits with delayed codes. Long runs with feedback on and a large positive or negative offset walk the trim through every fine-to-coarse carry until it saturates at each end. A signal-free run ends with the loop settled, where a zero estimate must leave the trim untouched.

// File: rtl/cofs_pkg.sv
package cofs_pkg;

    localparam int unsigned LFSR_W = 31;
    localparam int unsigned LFSR_TAP = 27;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    function automatic lfsr_t lfsr_next(input lfsr_t s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_TAP]};
    endfunction

endpackage

// File: rtl/cofs_chop_gen.sv
module cofs_chop_gen
    import cofs_pkg::*;
#(
    parameter lfsr_t       SEED = 31'h0000_1ACE,
    parameter int unsigned LAT  = 2
) (
    input  logic clk,
    input  logic rst,
    output logic chop_o,
    output logic chop_dly_o
);

    typedef struct packed {
        lfsr_t          lfsr;
        logic [LAT-1:0] pipe;
    } chop_st_t;

    localparam chop_st_t RST_ST = '{lfsr: SEED, pipe: '0};

    chop_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.lfsr = lfsr_next(st_q.lfsr);
        for (int i = LAT - 1; i > 0; i--) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.pipe[0] = st_q.lfsr[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign chop_o     = st_q.lfsr[0];
    assign chop_dly_o = st_q.pipe[LAT-1];

    // R2: a zero state would freeze the sign stream
    p_lfsr_live_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.lfsr != '0);

endmodule

// File: rtl/cofs_estimator.sv
module cofs_estimator #(
    parameter int unsigned CODE_W = 12,
    parameter int unsigned LOG2_N = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld_i,
    input  logic                     last_i,
    input  logic                     neg_i,
    input  logic signed [CODE_W-1:0] raw_i,
    output logic signed [CODE_W:0]   est_o
);

    localparam int unsigned ACC_W = CODE_W + LOG2_N + 1;
    localparam int unsigned EST_W = CODE_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [EST_W-1:0] est;
    } est_st_t;

    est_st_t st_d, st_q;

    logic signed [ACC_W-1:0] term;
    logic signed [ACC_W-1:0] sum;

    always_comb begin
        term = ACC_W'(raw_i);
        if (neg_i) begin
            term = -term;
        end
        sum  = $signed(st_q.acc) + term;
        st_d = st_q;
        if (vld_i) begin
            if (last_i) begin
                st_d.est = EST_W'(sum >>> LOG2_N);
                st_d.acc = '0;
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign est_o = $signed(st_q.est);

    // R7: an idle cycle leaves the running sum and estimate alone
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> ($stable(st_q.acc) && $stable(st_q.est)));

endmodule

// File: rtl/cofs_trim_step.sv
module cofs_trim_step
    import cofs_pkg::*;
#(
    parameter int unsigned CRS_W  = 4,
    parameter int unsigned FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_i,
    input  logic              est_pos_i,
    input  logic              est_neg_i,
    output logic [CRS_W-1:0]  coarse_o,
    output logic [FINE_W-1:0] fine_o
);

    localparam logic [CRS_W-1:0]  CRS_MAX  = '1;
    localparam logic [FINE_W-1:0] FINE_MAX = '1;
    localparam logic [CRS_W-1:0]  CRS_MID  = CRS_W'(1 << (CRS_W - 1));

    typedef struct packed {
        logic [CRS_W-1:0]  coarse;
        logic [FINE_W-1:0] fine;
    } trim_st_t;

    localparam trim_st_t RST_ST = '{coarse: CRS_MID, fine: '0};

    trim_st_t st_d, st_q;
    step_e    step;

    always_comb begin
        step = STEP_HOLD;
        if (upd_i && est_pos_i) begin
            step = STEP_DOWN;
        end else if (upd_i && est_neg_i) begin
            step = STEP_UP;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (step)
            STEP_DOWN: begin
                if (st_q.fine != '0) begin
                    st_d.fine = st_q.fine - 1'b1;
                end else if (st_q.coarse != '0) begin
                    st_d.coarse = st_q.coarse - 1'b1;
                    st_d.fine   = FINE_MAX;
                end
            end
            STEP_UP: begin
                if (st_q.fine != FINE_MAX) begin
                    st_d.fine = st_q.fine + 1'b1;
                end else if (st_q.coarse != CRS_MAX) begin
                    st_d.coarse = st_q.coarse + 1'b1;
                    st_d.fine   = '0;
                end
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign coarse_o = st_q.coarse;
    assign fine_o   = st_q.fine;

    // R8: no update request, no trim movement
    p_trim_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> ($stable(coarse_o) && $stable(fine_o)));

    // R9: lower limit holds under a further downward request
    p_trim_floor_r9: assert property (@(posedge clk) disable iff (rst)
        (upd_i && est_pos_i && coarse_o == '0 && fine_o == '0)
        |=> (coarse_o == '0 && fine_o == '0));

    // R9: upper limit holds under a further upward request
    p_trim_ceil_r9: assert property (@(posedge clk) disable iff (rst)
        (upd_i && est_neg_i && coarse_o == CRS_MAX && fine_o == FINE_MAX)
        |=> (coarse_o == CRS_MAX && fine_o == FINE_MAX));

endmodule

// File: rtl/cofs_ctrl.sv
module cofs_ctrl
    import cofs_pkg::*;
#(
    parameter int unsigned CODE_W = 12,
    parameter int unsigned LOG2_N = 20,
    parameter int unsigned NSTG   = 2,
    parameter int unsigned LAT    = 2,
    parameter int unsigned FINE_W = 4,
    parameter lfsr_t       SEED   = 31'h0000_1ACE
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       raw_vld_i,
    input  logic signed [CODE_W-1:0]   raw_code_i,
    input  logic                       fb_en_i,
    output logic [NSTG-1:0]            chop_o,
    output logic                       corr_vld_o,
    output logic signed [CODE_W+1:0]   corr_code_o,
    output logic                       est_vld_o,
    output logic [NSTG*(CODE_W+1)-1:0] est_o,
    output logic [NSTG*4-1:0]          trim_coarse_o,
    output logic [NSTG*FINE_W-1:0]     trim_fine_o
);

    localparam int unsigned EST_W  = CODE_W + 1;
    localparam int unsigned CORR_W = CODE_W + 2;
    localparam int unsigned CRS_W  = 4;

    typedef struct packed {
        logic [LOG2_N-1:0] cnt;
        logic              corr_vld;
        logic [CORR_W-1:0] corr;
        logic              est_vld;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NSTG-1:0]         chop_dly;
    logic signed [EST_W-1:0] est_w [NSTG];
    logic                    blk_last;
    logic signed [CORR_W-1:0] diff;

    assign blk_last = &st_q.cnt;

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        localparam lfsr_t STG_SEED = SEED ^ (lfsr_t'(s) << 20);

        cofs_chop_gen #(
            .SEED (STG_SEED),
            .LAT  (LAT)
        ) u_chop (
            .clk        (clk),
            .rst        (rst),
            .chop_o     (chop_o[s]),
            .chop_dly_o (chop_dly[s])
        );

        cofs_estimator #(
            .CODE_W (CODE_W),
            .LOG2_N (LOG2_N)
        ) u_est (
            .clk    (clk),
            .rst    (rst),
            .vld_i  (raw_vld_i),
            .last_i (blk_last),
            .neg_i  ((s == 0) ? 1'b0 : chop_dly[s]),
            .raw_i  (raw_code_i),
            .est_o  (est_w[s])
        );

        cofs_trim_step #(
            .CRS_W  (CRS_W),
            .FINE_W (FINE_W)
        ) u_trim (
            .clk       (clk),
            .rst       (rst),
            .upd_i     (st_q.est_vld && fb_en_i),
            .est_pos_i (!est_w[s][EST_W-1] && (est_w[s] != '0)),
            .est_neg_i (est_w[s][EST_W-1]),
            .coarse_o  (trim_coarse_o[s*CRS_W +: CRS_W]),
            .fine_o    (trim_fine_o[s*FINE_W +: FINE_W])
        );

        assign est_o[s*EST_W +: EST_W] = est_w[s];
    end

    always_comb begin
        diff = CORR_W'(raw_code_i) - CORR_W'(est_w[0]);
        st_d = st_q;
        st_d.corr_vld = raw_vld_i;
        st_d.est_vld  = raw_vld_i && blk_last;
        if (raw_vld_i) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.corr = chop_dly[0] ? -diff : diff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign corr_vld_o  = st_q.corr_vld;
    assign corr_code_o = $signed(st_q.corr);
    assign est_vld_o   = st_q.est_vld;

    // R6: every accepted code yields a corrected sample one cycle later
    p_corr_follow_r6: assert property (@(posedge clk) disable iff (rst)
        raw_vld_i |=> corr_vld_o);

    // R7: an idle input cycle yields no corrected sample
    p_corr_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !raw_vld_i |=> !corr_vld_o);

    // R4: the update strobe lasts a single cycle
    p_est_single_r4: assert property (@(posedge clk) disable iff (rst)
        est_vld_o |=> !est_vld_o);

endmodule

// File: tb/cofs_ctrl_tb.sv
module cofs_ctrl_tb;

    localparam int CODE_W = 12;
    localparam int LOG2_N = 6;
    localparam int NSTG   = 2;
    localparam int LAT    = 2;
    localparam int FINE_W = 4;
    localparam logic [30:0] SEED = 31'h0000_1ACE;
    localparam int N      = 1 << LOG2_N;
    localparam int EST_W  = CODE_W + 1;
    localparam int TMID   = 8 << FINE_W;
    localparam int TMAX   = (16 << FINE_W) - 1;
    localparam int CMAX   = (1 << (CODE_W - 1)) - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                       rst;
    logic                       raw_vld_i;
    logic signed [CODE_W-1:0]   raw_code_i;
    logic                       fb_en_i;
    logic [NSTG-1:0]            chop_o;
    logic                       corr_vld_o;
    logic signed [CODE_W+1:0]   corr_code_o;
    logic                       est_vld_o;
    logic [NSTG*EST_W-1:0]      est_o;
    logic [NSTG*4-1:0]          trim_coarse_o;
    logic [NSTG*FINE_W-1:0]     trim_fine_o;

    cofs_ctrl #(
        .CODE_W (CODE_W), .LOG2_N (LOG2_N), .NSTG (NSTG),
        .LAT (LAT), .FINE_W (FINE_W), .SEED (SEED)
    ) u_dut (
        .clk (clk), .rst (rst), .raw_vld_i (raw_vld_i), .raw_code_i (raw_code_i),
        .fb_en_i (fb_en_i), .chop_o (chop_o), .corr_vld_o (corr_vld_o),
        .corr_code_o (corr_code_o), .est_vld_o (est_vld_o), .est_o (est_o),
        .trim_coarse_o (trim_coarse_o), .trim_fine_o (trim_fine_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    logic [30:0]     m_lfsr [NSTG];
    longint          m_acc  [NSTG];
    longint          m_est  [NSTG];
    int              m_trim [NSTG];
    int              m_cnt;
    bit              e_corr_vld;
    longint          e_corr;
    bit              e_est_vld;
    logic [NSTG-1:0] hist [$];

    // stimulus knobs
    int zb [NSTG];
    int vamp;
    int gap_pct;
    bit fb;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint est_port(input int s);
        return longint'($signed(est_o[s*EST_W +: EST_W]));
    endfunction

    function automatic int trim_port(input int s);
        return int'(trim_coarse_o[s*4 +: 4]) * (1 << FINE_W) + int'(trim_fine_o[s*FINE_W +: FINE_W]);
    endfunction

    task automatic compare_outputs();
        for (int s = 0; s < NSTG; s++) chk("R2 chop bit", longint'(chop_o[s]), longint'(m_lfsr[s][0]));
        chk("R7 corr_vld", longint'(corr_vld_o), longint'(e_corr_vld));
        if (e_corr_vld) chk("R6 corrected sample (R3 alignment)", longint'(corr_code_o), e_corr);
        chk("R4 est_vld pulse", longint'(est_vld_o), longint'(e_est_vld));
        if (e_est_vld) begin
            chk("R4 stage0 estimate", est_port(0), m_est[0]);
            for (int s = 1; s < NSTG; s++) chk("R5 stage estimate", est_port(s), m_est[s]);
        end
        for (int s = 0; s < NSTG; s++) chk("R8 trim code", longint'(trim_port(s)), longint'(m_trim[s]));
    endtask

    task automatic drive_and_predict();
        logic [NSTG-1:0] p;
        bit     vld;
        int     raw;
        int     sg [NSTG];
        p   = '0;
        vld = 1'b0;
        hist.push_back(chop_o);
        if (hist.size() > LAT) begin
            p   = hist.pop_front();
            vld = ($urandom_range(99) >= gap_pct);
        end
        for (int s = 0; s < NSTG; s++) sg[s] = p[s] ? -1 : 1;
        raw = sg[0] * ($urandom_range(2 * vamp) - vamp) + zb[0] + trim_port(0) - TMID;
        for (int s = 1; s < NSTG; s++) raw += sg[s] * (zb[s] + trim_port(s) - TMID);
        if (raw > CMAX) raw = CMAX;
        if (raw < -CMAX - 1) raw = -CMAX - 1;
        raw_vld_i  = vld;
        raw_code_i = CODE_W'(raw);
        fb_en_i    = fb;
        // trim reacts to the estimate shown in this cycle
        if (e_est_vld && fb) begin
            for (int s = 0; s < NSTG; s++) begin
                if (m_est[s] > 0 && m_trim[s] > 0) m_trim[s]--;
                else if (m_est[s] < 0 && m_trim[s] < TMAX) m_trim[s]++;
            end
        end
        e_corr_vld = vld;
        if (vld) e_corr = (longint'(raw) - m_est[0]) * sg[0];
        e_est_vld = 1'b0;
        if (vld) begin
            m_acc[0] += raw;
            for (int s = 1; s < NSTG; s++) m_acc[s] += raw * sg[s];
            m_cnt++;
            if (m_cnt == N) begin
                for (int s = 0; s < NSTG; s++) begin
                    m_est[s] = m_acc[s] >>> LOG2_N;
                    m_acc[s] = 0;
                end
                m_cnt     = 0;
                e_est_vld = 1'b1;
            end
        end
        for (int s = 0; s < NSTG; s++) m_lfsr[s] = {m_lfsr[s][29:0], m_lfsr[s][30] ^ m_lfsr[s][27]};
    endtask

    task automatic run_blocks(input int nblk);
        int target;
        target = nblk;
        while (target > 0) begin
            @(negedge clk);
            compare_outputs();
            drive_and_predict();
            if (e_est_vld) target--;
        end
    endtask

    initial begin
        rst = 1'b1; raw_vld_i = 1'b0; raw_code_i = '0; fb_en_i = 1'b0;
        for (int s = 0; s < NSTG; s++) begin
            m_lfsr[s] = SEED ^ (31'(s) << 20);
            m_acc[s] = 0; m_est[s] = 0; m_trim[s] = TMID;
        end
        m_cnt = 0; e_corr_vld = 0; e_corr = 0; e_est_vld = 0;
        zb[0] = 37; zb[1] = -21; vamp = 500; gap_pct = 0; fb = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        for (int s = 0; s < NSTG; s++) begin
            chk("R1 reset chop", longint'(chop_o[s]), longint'(m_lfsr[s][0]));
            chk("R1 reset estimate", est_port(s), 0);
            chk("R1 reset trim", longint'(trim_port(s)), TMID);
        end
        chk("R1 reset corr_vld", longint'(corr_vld_o), 0);
        chk("R1 reset est_vld", longint'(est_vld_o), 0);
        rst = 1'b0;
        drive_and_predict();

        // continuous traffic, two distinct offsets, no feedback
        run_blocks(10);
        // gapped traffic
        gap_pct = 30;
        run_blocks(10);
        // feedback, large positive offset walks trim to the floor
        gap_pct = 10; fb = 1'b1; zb[0] = 300; zb[1] = 40;
        run_blocks(180);
        chk("R9 trim floor", longint'(trim_port(0)), 0);
        // large negative offset walks trim to the ceiling
        zb[0] = -300; zb[1] = -40;
        run_blocks(280);
        chk("R9 trim ceiling", longint'(trim_port(0)), TMAX);
        // signal-free settling around zero
        vamp = 0; zb[0] = 0; zb[1] = 0; gap_pct = 0;
        run_blocks(150);
        chk("R8 settled stage0 estimate", est_port(0), 0);
        chk("R8 settled stage0 trim", longint'(trim_port(0)), TMID);
        // feedback off: trim must hold
        fb = 1'b0; zb[0] = 200;
        run_blocks(5);
        chk("R8 trim held with feedback off", longint'(trim_port(0)), TMID);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule